// File: doc/BRIEF.md
# Debug Emulation Mode Controller

This block keeps track of whether a processor core is running in its debug emulation mode. It collects three ways in and one way out. The first way in is a forced-entry configuration bit that is looked at only on the first clock after reset is released. The second is a debug interrupt. The third is a trace exception, which counts only while a trace-enable bit is set. The only way out is a return-from-exception strobe from instruction decode.

While the core is emulating, the block drives the interrupt level it passes on to zero, so even the non-maskable level 7 is blocked. When a mapping bit is set, the block also turns off the cache and on-chip SRAM enables and steers every memory access into a dedicated debug address space. It does this by overriding the bus transfer type and transfer modifier. The override and the interrupt mask already apply in the cycle in which entry is decided, so the stack-frame writes and the vector fetch of the entering exception are covered.

A registered 4-bit status code marks the cycle after each transition, so an external trace probe can follow mode changes.

Top module: `emu_mode_ctrl`

## Requirements
- R1: If `force_cfg` is 1 on the first rising clock edge after `rst_n` goes high, `emu_mode` is 1 after that edge. A `force_cfg` value on any later edge has no effect.
- R2: A `dbg_irq` at a clock edge while not emulating sets `emu_mode` after that edge.
- R3: A `trace_exc` causes entry only when `trace_en` is also 1. With `trace_en` at 0 it has no effect.
- R4: An `rte` strobe while emulating clears `emu_mode` after that edge. An `rte` strobe while not emulating has no effect.
- R5: `pst_code` reads 4'hD for exactly the one cycle after an entry edge and 4'h7 for exactly the one cycle after an exit edge. In every other cycle it reads 4'h0.
- R6: Entry causes that arrive while already emulating produce no further 4'hD. If an entry cause and `rte` arrive together, entry wins when not emulating and exit wins when emulating.
- R7: While emulating, or in the cycle an entry cause is present, `irq_out` is 0 for every input level, including 7. In all other cycles it equals `irq_in`.
- R8: With `map_en` at 1, while emulating or in the entry cycle, `tt_out` is 2'h2 and `tm_out` is 3'h6 when `acc_fetch` is 1 (instruction fetch) or 3'h5 otherwise (data). In the same cycles `cache_en_out` and `sram_en_out` are 0.
- R9: With `map_en` at 0, or when neither emulating nor entering, `tt_out`, `tm_out`, `cache_en_out` and `sram_en_out` equal their inputs.
- R10: While `rst_n` is 0, `emu_mode` is 0 and `pst_code` is 4'h0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| force_cfg | input | 1 | Forced-entry control bit, sampled at reset release |
| dbg_irq | input | 1 | Debug interrupt |
| trace_en | input | 1 | Trace-to-emulation enable bit |
| trace_exc | input | 1 | Trace exception taken |
| rte | input | 1 | Return-from-exception strobe |
| map_en | input | 1 | Enable debug address-space remapping |
| irq_in | input | 3 | Pending interrupt level from the controller |
| tt_in | input | 2 | Transfer type of the current access |
| tm_in | input | 3 | Transfer modifier of the current access |
| acc_fetch | input | 1 | Current access is an instruction fetch |
| cache_en_in | input | 1 | Cache enable from the configuration |
| sram_en_in | input | 1 | SRAM enable from the configuration |
| emu_mode | output | 1 | Core is in emulation mode |
| pst_code | output | 4 | Processor status code |
| irq_out | output | 3 | Interrupt level passed to the core |
| tt_out | output | 2 | Transfer type after override |
| tm_out | output | 3 | Transfer modifier after override |
| cache_en_out | output | 1 | Cache enable after override |
| sram_en_out | output | 1 | SRAM enable after override |

## Verification
The assertions check the following on every cycle: entry on a debug interrupt and exit on `rte` with the matching status code; that 4'hD appears only on the rising edge of the mode flag; that interrupts stay masked while emulating; and that the remapped transfer type and modifier are correct whenever mapping is active. Only the bench scenarios can show the behaviours that depend on history or on inputs being absent. These are: forced entry, which happens only on the first edge after reset; a trace exception being ignored without its enable; the priority between `rte` and an entry cause that arrive together; and pass-through of every access field when mapping is off.

// File: rtl/emu_pkg.sv
package emu_pkg;
    localparam int PST_W = 4;
    localparam int IRQ_W = 3;
    localparam int TT_W  = 2;
    localparam int TM_W  = 3;

    localparam logic [PST_W-1:0] PST_IDLE  = 4'h0;
    localparam logic [PST_W-1:0] PST_ENTER = 4'hD;
    localparam logic [PST_W-1:0] PST_LEAVE = 4'h7;

    localparam logic [TT_W-1:0] TT_DEBUG    = 2'h2;
    localparam logic [TM_W-1:0] TM_DBG_DATA = 3'h5;
    localparam logic [TM_W-1:0] TM_DBG_INSN = 3'h6;

    typedef struct packed {
        logic             emu;    // emulation mode flag
        logic [PST_W-1:0] pst;    // status code shown this cycle
        logic             first;  // first cycle after reset release
    } emu_state_t;
endpackage

// File: rtl/emu_entry_detect.sv
module emu_entry_detect (
    input  logic first_cycle,
    input  logic force_cfg,
    input  logic dbg_irq,
    input  logic trace_en,
    input  logic trace_exc,
    output logic enter_req
);
    logic from_force, from_trace;

    always_comb begin
        from_force = first_cycle & force_cfg;
        from_trace = trace_en & trace_exc;
        enter_req  = from_force | dbg_irq | from_trace;
    end
endmodule

// File: rtl/emu_state_ctrl.sv
module emu_state_ctrl
    import emu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter_req,
    input  logic             rte,
    output logic             emu_q_o,
    output logic             first_q_o,
    output logic [PST_W-1:0] pst_q_o
);
    emu_state_t state_d, state_q;

    always_comb begin
        state_d       = state_q;
        state_d.first = 1'b0;
        state_d.pst   = PST_IDLE;
        if (!state_q.emu) begin
            if (enter_req) begin
                state_d.emu = 1'b1;
                state_d.pst = PST_ENTER;
            end
        end else if (rte) begin
            state_d.emu = 1'b0;
            state_d.pst = PST_LEAVE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.emu   <= 1'b0;
            state_q.pst   <= PST_IDLE;
            state_q.first <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign emu_q_o   = state_q.emu;
    assign first_q_o = state_q.first;
    assign pst_q_o   = state_q.pst;
endmodule

// File: rtl/emu_bus_remap.sv
module emu_bus_remap
    import emu_pkg::*;
#(
    parameter int IRQ_WIDTH = IRQ_W
) (
    input  logic                 active,
    input  logic                 map_en,
    input  logic [IRQ_WIDTH-1:0] irq_in,
    input  logic [TT_W-1:0]      tt_in,
    input  logic [TM_W-1:0]      tm_in,
    input  logic                 acc_fetch,
    input  logic                 cache_en_in,
    input  logic                 sram_en_in,
    output logic [IRQ_WIDTH-1:0] irq_out,
    output logic [TT_W-1:0]      tt_out,
    output logic [TM_W-1:0]      tm_out,
    output logic                 cache_en_out,
    output logic                 sram_en_out
);
    logic remap;

    always_comb begin
        remap        = active & map_en;
        irq_out      = active ? '0 : irq_in;
        tt_out       = remap ? TT_DEBUG : tt_in;
        tm_out       = remap ? (acc_fetch ? TM_DBG_INSN : TM_DBG_DATA) : tm_in;
        cache_en_out = cache_en_in & ~remap;
        sram_en_out  = sram_en_in & ~remap;
    end
endmodule

// File: rtl/emu_mode_ctrl.sv
module emu_mode_ctrl
    import emu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_cfg,
    input  logic             dbg_irq,
    input  logic             trace_en,
    input  logic             trace_exc,
    input  logic             rte,
    input  logic             map_en,
    input  logic [IRQ_W-1:0] irq_in,
    input  logic [TT_W-1:0]  tt_in,
    input  logic [TM_W-1:0]  tm_in,
    input  logic             acc_fetch,
    input  logic             cache_en_in,
    input  logic             sram_en_in,
    output logic             emu_mode,
    output logic [PST_W-1:0] pst_code,
    output logic [IRQ_W-1:0] irq_out,
    output logic [TT_W-1:0]  tt_out,
    output logic [TM_W-1:0]  tm_out,
    output logic             cache_en_out,
    output logic             sram_en_out
);
    logic enter_req, first_q, emu_q, active;

    emu_entry_detect u_detect (
        .first_cycle (first_q),
        .force_cfg   (force_cfg),
        .dbg_irq     (dbg_irq),
        .trace_en    (trace_en),
        .trace_exc   (trace_exc),
        .enter_req   (enter_req)
    );

    emu_state_ctrl u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter_req (enter_req),
        .rte       (rte),
        .emu_q_o   (emu_q),
        .first_q_o (first_q),
        .pst_q_o   (pst_code)
    );

    // Entry cycle counts as active so the entering exception is covered.
    assign active   = emu_q | enter_req;
    assign emu_mode = emu_q;

    emu_bus_remap #(.IRQ_WIDTH(IRQ_W)) u_remap (
        .active       (active),
        .map_en       (map_en),
        .irq_in       (irq_in),
        .tt_in        (tt_in),
        .tm_in        (tm_in),
        .acc_fetch    (acc_fetch),
        .cache_en_in  (cache_en_in),
        .sram_en_in   (sram_en_in),
        .irq_out      (irq_out),
        .tt_out       (tt_out),
        .tm_out       (tm_out),
        .cache_en_out (cache_en_out),
        .sram_en_out  (sram_en_out)
    );
endmodule

// File: rtl/emu_mode_ctrl_chk.sv
module emu_mode_ctrl_chk
    import emu_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             dbg_irq,
    input logic             rte,
    input logic             map_en,
    input logic             acc_fetch,
    input logic             emu_mode,
    input logic [PST_W-1:0] pst_code,
    input logic [IRQ_W-1:0] irq_out,
    input logic [TT_W-1:0]  tt_out,
    input logic [TM_W-1:0]  tm_out
);
    a_r2_dbg_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (!emu_mode && dbg_irq) |=> (emu_mode && pst_code == PST_ENTER));

    a_r4_rte_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (emu_mode && rte) |=> (!emu_mode && pst_code == PST_LEAVE));

    a_r5_enter_code_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (pst_code == PST_ENTER) |-> $rose(emu_mode));

    a_r6_no_second_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (emu_mode && !rte) |=> (pst_code != PST_ENTER));

    a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        emu_mode |-> (irq_out == '0));

    a_r8_remap_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (emu_mode && map_en) |->
            (tt_out == TT_DEBUG && tm_out == (acc_fetch ? TM_DBG_INSN : TM_DBG_DATA)));
endmodule

bind emu_mode_ctrl emu_mode_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbg_irq   (dbg_irq),
    .rte       (rte),
    .map_en    (map_en),
    .acc_fetch (acc_fetch),
    .emu_mode  (emu_mode),
    .pst_code  (pst_code),
    .irq_out   (irq_out),
    .tt_out    (tt_out),
    .tm_out    (tm_out)
);

// File: tb/emu_mode_ctrl_tb.sv
module emu_mode_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       force_cfg = 1'b0, dbg_irq = 1'b0, trace_en = 1'b0, trace_exc = 1'b0;
    logic       rte = 1'b0, map_en = 1'b0, acc_fetch = 1'b0;
    logic       cache_en_in = 1'b1, sram_en_in = 1'b1;
    logic [2:0] irq_in = 3'd0;
    logic [1:0] tt_in = 2'd0;
    logic [2:0] tm_in = 3'd0;
    logic       emu_mode, cache_en_out, sram_en_out;
    logic [3:0] pst_code;
    logic [2:0] irq_out, tm_out;
    logic [1:0] tt_out;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    emu_mode_ctrl u_dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {force, dbg, trace_en, trace_exc, rte, exp_emu, exp_pst[3:0]}
    localparam logic [9:0] VEC [14] = '{
        {5'b00000, 1'b0, 4'h0},  // R10 idle after release
        {5'b00010, 1'b0, 4'h0},  // R3 trace exc without enable
        {5'b00110, 1'b1, 4'hD},  // R3 trace entry
        {5'b00000, 1'b1, 4'h0},  // R5 code lasts one cycle
        {5'b01000, 1'b1, 4'h0},  // R6 dbg while emulating
        {5'b00001, 1'b0, 4'h7},  // R4 exit
        {5'b10000, 1'b0, 4'h0},  // R1 late force ignored
        {5'b00001, 1'b0, 4'h0},  // R4 rte while idle ignored
        {5'b01000, 1'b1, 4'hD},  // R2 debug interrupt entry
        {5'b00001, 1'b0, 4'h7},  // R4 exit
        {5'b01001, 1'b1, 4'hD},  // R6 entry wins when idle
        {5'b01001, 1'b0, 4'h7},  // R6 exit wins when emulating
        {5'b00000, 1'b0, 4'h0},  // R5 idle code
        {5'b00010, 1'b0, 4'h0}   // R3 trace exc ignored again
    };

    task automatic idle_inputs();
        {force_cfg, dbg_irq, trace_en, trace_exc, rte} = 5'b0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 emu in reset", {7'd0, emu_mode}, 8'd0);
        chk("R10 pst in reset", {4'd0, pst_code}, 8'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            {force_cfg, dbg_irq, trace_en, trace_exc, rte} = VEC[i][9:5];
            @(posedge clk);
            #1;
            chk($sformatf("R5/R6 vec%0d emu", i), {7'd0, emu_mode}, {7'd0, VEC[i][4]});
            chk($sformatf("R5/R6 vec%0d pst", i), {4'd0, pst_code}, {4'd0, VEC[i][3:0]});
        end

        // R1 forced entry at reset release
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        force_cfg = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 forced entry", {7'd0, emu_mode}, 8'd1);
        chk("R1 entry code", {4'd0, pst_code}, 8'hD);
        force_cfg = 1'b0;

        // R7 level-7 masked while emulating
        @(negedge clk);
        irq_in = 3'd7;
        #1;
        chk("R7 level 7 masked", {5'd0, irq_out}, 8'd0);

        // R8 remap while emulating, data then fetch
        map_en = 1'b1; tt_in = 2'd0; tm_in = 3'd1; acc_fetch = 1'b0;
        #1;
        chk("R8 tt data", {6'd0, tt_out}, 8'd2);
        chk("R8 tm data", {5'd0, tm_out}, 8'd5);
        chk("R8 cache off", {7'd0, cache_en_out}, 8'd0);
        chk("R8 sram off", {7'd0, sram_en_out}, 8'd0);
        acc_fetch = 1'b1;
        #1;
        chk("R8 tm fetch", {5'd0, tm_out}, 8'd6);

        // leave emulation
        rte = 1'b1;
        @(posedge clk);
        #1;
        rte = 1'b0;
        chk("R4 exit after forced", {7'd0, emu_mode}, 8'd0);

        // R9 pass-through while idle with map on
        @(negedge clk);
        tt_in = 2'd1; tm_in = 3'd3; acc_fetch = 1'b0;
        #1;
        chk("R7 irq passes when idle", {5'd0, irq_out}, 8'd7);
        chk("R9 tt pass", {6'd0, tt_out}, 8'd1);
        chk("R9 tm pass", {5'd0, tm_out}, 8'd3);
        chk("R9 cache pass", {7'd0, cache_en_out}, 8'd1);

        // R8 remap applies in the entry cycle itself
        dbg_irq = 1'b1; acc_fetch = 1'b1;
        #1;
        chk("R8 entry-cycle tt", {6'd0, tt_out}, 8'd2);
        chk("R8 entry-cycle tm", {5'd0, tm_out}, 8'd6);
        chk("R7 entry-cycle mask", {5'd0, irq_out}, 8'd0);
        @(posedge clk);
        #1;
        dbg_irq = 1'b0;
        chk("R2 entered", {7'd0, emu_mode}, 8'd1);

        // R9 map off while emulating: access fields pass through
        @(negedge clk);
        map_en = 1'b0; tm_in = 3'd4;
        #1;
        chk("R9 tm pass map off", {5'd0, tm_out}, 8'd4);
        chk("R9 sram pass map off", {7'd0, sram_en_out}, 8'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule